// File: doc/BRIEF.md
# Serial EEPROM Host Sequencer (three-wire, start-bit framed)

This block is the host side of a three-wire serial EEPROM link. It takes one request at a time and turns it into chip-select, serial clock and serial data waveforms. A request holds a command code, an address, write data, a word-width setting and a burst length. The serial clock is built from the core clock. Its half period is set in core cycles at run time, so the link rate can be held under the memory's limit for any core frequency.

Each instruction is framed from its fields and shifted out MSB first. On reads, the first returned bit is a placeholder and is skipped. The words that follow are returned one per `rd_valid` strobe, and a burst keeps the clock running over consecutive addresses. Commands that program the array end with a timed chip-select low gap. The host then raises chip select again and polls the data-out line until the memory reports ready, or until a poll budget runs out. A single pulse on `done` or `timeout` closes every sequence.

Top module: `mwh_eeprom_host`

## Requirements
- R1: Every frame is a 1 start bit, then a 2-bit opcode, then the address field, then any data field, all MSB first. Opcodes are read=10, write=01, erase=11, and 00 for the four whole-array and enable commands. Command codes are 0 read, 1 write, 2 erase, 3 write-enable, 4 write-disable, 5 erase-all, 6 write-all.
- R2: With `req_org16`=1 the address field is `req_addr[7:0]` (8 bits) and the data field is `req_wdata[15:0]`. With `req_org16`=0 the address field is `req_addr[8:0]` (9 bits) and the data field is `req_wdata[7:0]`.
- R3: Write-enable, write-disable, erase-all and write-all send opcode 00 with 11, 00, 10 and 01 in the top two address-field bits and zeros below. Only write-all carries a data field.
- R4: `mw_di` never changes on a cycle where `mw_sk` rises. `mw_sk` is low whenever `mw_cs` is low. Each SK high and low phase lasts max(`cfg_half`,1) core cycles.
- R5: On a read, the bit that arrives after the last address bit is discarded. Each following group of 16 (x16) or 8 (x8) bits is assembled MSB first and presented on `rd_data` with a one-cycle `rd_valid`. In x8 mode bits 15:8 are zero.
- R6: A read returns `req_words` words (0 counts as 1) from consecutive addresses with chip select held high. The total SK rising edges equal the frame length plus words times data width.
- R7: Write, erase, erase-all and write-all drop `mw_cs` for exactly max(`cfg_gap`,1) cycles after the frame. The host then raises it and finishes with `done` once `mw_do` reads high, which is checked from the second poll cycle on.
- R8: If `mw_do` has not read high by poll cycle max(`cfg_tmo`,1), the sequence ends with a `timeout` pulse, no `done`, and `mw_cs` low.
- R9: `req_ready` is high only while idle. `busy` is high from acceptance to the end. Exactly one of `done` or `timeout` pulses for one cycle as `busy` falls.
- R10: After reset `mw_cs`, `mw_sk`, `busy`, `rd_valid`, `done` and `timeout` are 0 and `req_ready` is 1.
- R11: Read, write-enable and write-disable raise `mw_cs` only once and finish without a gap or polling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on this cycle if valid |
| req_cmd | input | 3 | Command code (see R1) |
| req_org16 | input | 1 | 1 = 16-bit words, 0 = 8-bit words |
| req_addr | input | 9 | Word address |
| req_wdata | input | 16 | Write data |
| req_words | input | WORDS_W | Read burst length, 0 treated as 1 |
| cfg_half | input | HALF_W | SK half period in core cycles |
| cfg_gap | input | GAP_W | Chip-select low gap after program frames |
| cfg_tmo | input | TMO_W | Poll budget in core cycles |
| mw_cs | output | 1 | Chip select to memory |
| mw_sk | output | 1 | Serial clock to memory |
| mw_di | output | 1 | Serial data to memory |
| mw_do | input | 1 | Serial data / ready status from memory |
| busy | output | 1 | Sequence in progress |
| rd_valid | output | 1 | Read word strobe |
| rd_data | output | 16 | Read word |
| done | output | 1 | Sequence finished normally |
| timeout | output | 1 | Poll budget exhausted |

## Verification
On every cycle, the assertions check the link rules: DI is stable at SK rise and SK is parked low outside chip select. They also check that chip select stays low in the gap, that read strobes and timeouts come only from their own phases, and that every end of `busy` carries exactly one of the two end pulses. Only the bench scenarios can show the frame contents, address and data widths per word width, skipping of the placeholder bit, burst address wrap, exact gap length and rising-edge counts. The bench runs these against a behavioural memory model with a shadow array.

// File: rtl/mwh_pkg.sv
package mwh_pkg;

    localparam int AW16    = 8;
    localparam int AW8     = AW16 + 1;
    localparam int DW16    = 16;
    localparam int DW8     = 8;
    localparam int FR16    = 3 + AW16 + DW16;
    localparam int FR8     = 3 + AW8 + DW8;
    localparam int FRAME_W = (FR16 > FR8) ? FR16 : FR8;
    localparam int LEN_W   = $clog2(FRAME_W + 1);
    localparam int BCW     = $clog2(DW16 + 1);

    typedef enum logic [2:0] {
        CMD_READ  = 3'd0,
        CMD_WRITE = 3'd1,
        CMD_ERASE = 3'd2,
        CMD_WEN   = 3'd3,
        CMD_WDS   = 3'd4,
        CMD_ERALL = 3'd5,
        CMD_WRALL = 3'd6
    } cmd_e;

    typedef enum logic [2:0] {
        S_IDLE, S_SEND, S_RECV, S_GAP, S_POLL
    } state_e;

    typedef struct packed {
        logic [FRAME_W-1:0] bits;
        logic [LEN_W-1:0]   len;
    } frame_t;

    function automatic logic is_prog(cmd_e c);
        return (c == CMD_WRITE) || (c == CMD_ERASE) ||
               (c == CMD_ERALL) || (c == CMD_WRALL);
    endfunction

    function automatic frame_t mk_frame(cmd_e c, logic org16,
                                        logic [AW8-1:0] addr,
                                        logic [DW16-1:0] wdata);
        frame_t             f;
        logic [1:0]         op;
        logic [1:0]         sub;
        logic               use_sub;
        logic               has_data;
        int unsigned        alen;
        int unsigned        dlen;
        int unsigned        len;
        logic [FRAME_W-1:0] acc;
        logic [FRAME_W-1:0] afield;
        logic [FRAME_W-1:0] dfield;
        alen     = org16 ? AW16 : AW8;
        dlen     = org16 ? DW16 : DW8;
        op       = 2'b00;
        sub      = 2'b00;
        use_sub  = 1'b0;
        has_data = 1'b0;
        case (c)
            CMD_READ:  op = 2'b10;
            CMD_WRITE: begin op = 2'b01; has_data = 1'b1; end
            CMD_ERASE: op = 2'b11;
            CMD_WEN:   begin use_sub = 1'b1; sub = 2'b11; end
            CMD_ERALL: begin use_sub = 1'b1; sub = 2'b10; end
            CMD_WRALL: begin use_sub = 1'b1; sub = 2'b01; has_data = 1'b1; end
            default:   begin use_sub = 1'b1; sub = 2'b00; end
        endcase
        if (use_sub)
            afield = FRAME_W'(sub) << (alen - 2);
        else
            afield = FRAME_W'(addr) & ((FRAME_W'(1) << alen) - FRAME_W'(1));
        dfield = FRAME_W'(wdata) & ((FRAME_W'(1) << dlen) - FRAME_W'(1));
        acc    = FRAME_W'({1'b1, op});
        acc    = (acc << alen) | afield;
        len    = 3 + alen;
        if (has_data) begin
            acc = (acc << dlen) | dfield;
            len = len + dlen;
        end
        f.bits = acc << (FRAME_W - len);
        f.len  = LEN_W'(len);
        return f;
    endfunction

endpackage

// File: rtl/mwh_sk_gen.sv
module mwh_sk_gen #(
    parameter int HALF_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic [HALF_W-1:0] half,
    output logic              sk,
    output logic              rise,
    output logic              fall
);
    logic [HALF_W-1:0] cnt;
    logic [HALF_W-1:0] lim;
    logic              tick;

    assign lim  = (half == '0) ? '0 : half - 1'b1;
    assign tick = run && (cnt == lim);
    assign rise = tick && !sk;
    assign fall = tick && sk;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
            sk  <= 1'b0;
        end else if (tick) begin
            cnt <= '0;
            sk  <= ~sk;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    AST_SK_PARKED: assert property (@(posedge clk) disable iff (rst)
        !run |=> !sk) else $error("SK toggles while stopped"); // R4
endmodule

// File: rtl/mwh_wait_cnt.sv
module mwh_wait_cnt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    output logic [W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst || !en)
            cnt <= '0;
        else if (cnt != '1)
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/mwh_eeprom_host.sv
module mwh_eeprom_host
    import mwh_pkg::*;
#(
    parameter int HALF_W  = 8,
    parameter int GAP_W   = 8,
    parameter int TMO_W   = 16,
    parameter int WORDS_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [2:0]         req_cmd,
    input  logic               req_org16,
    input  logic [AW8-1:0]     req_addr,
    input  logic [DW16-1:0]    req_wdata,
    input  logic [WORDS_W-1:0] req_words,
    input  logic [HALF_W-1:0]  cfg_half,
    input  logic [GAP_W-1:0]   cfg_gap,
    input  logic [TMO_W-1:0]   cfg_tmo,
    output logic               mw_cs,
    output logic               mw_sk,
    output logic               mw_di,
    input  logic               mw_do,
    output logic               busy,
    output logic               rd_valid,
    output logic [DW16-1:0]    rd_data,
    output logic               done,
    output logic               timeout
);
    state_e             state;
    logic [FRAME_W-1:0] frame;
    logic [LEN_W-1:0]   bits_left;
    cmd_e               cmd_q;
    logic               org_q;
    logic [BCW-1:0]     bit_cnt;
    logic [WORDS_W-1:0] words_left;
    logic [DW16-1:0]    rsh;
    logic               sk_rise;
    logic               sk_fall;
    logic [GAP_W-1:0]   gap_cnt;
    logic [TMO_W-1:0]   poll_cnt;
    logic [GAP_W-1:0]   gap_lim;
    logic [TMO_W-1:0]   tmo_lim;
    logic [BCW-1:0]     dlen;
    logic [DW16-1:0]    word_in;
    frame_t             nf;

    assign req_ready = (state == S_IDLE);
    assign busy      = (state != S_IDLE);
    assign mw_di     = (state == S_SEND) && frame[FRAME_W-1];
    assign gap_lim   = (cfg_gap == '0) ? '0 : cfg_gap - 1'b1;
    assign tmo_lim   = (cfg_tmo == '0) ? TMO_W'(1) : cfg_tmo;
    assign dlen      = org_q ? BCW'(DW16) : BCW'(DW8);
    assign nf        = mk_frame(cmd_e'(req_cmd), req_org16, req_addr, req_wdata);
    assign word_in   = org_q ? {rsh[DW16-2:0], mw_do}
                             : {{(DW16-DW8){1'b0}}, rsh[DW8-2:0], mw_do};

    mwh_sk_gen #(.HALF_W(HALF_W)) u_sk (
        .clk(clk), .rst(rst),
        .run((state == S_SEND) || (state == S_RECV)),
        .half(cfg_half), .sk(mw_sk), .rise(sk_rise), .fall(sk_fall)
    );

    mwh_wait_cnt #(.W(GAP_W)) u_gap (
        .clk(clk), .rst(rst), .en(state == S_GAP), .cnt(gap_cnt)
    );

    mwh_wait_cnt #(.W(TMO_W)) u_poll (
        .clk(clk), .rst(rst), .en(state == S_POLL), .cnt(poll_cnt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= S_IDLE;
            frame      <= '0;
            bits_left  <= '0;
            cmd_q      <= CMD_READ;
            org_q      <= 1'b1;
            bit_cnt    <= '0;
            words_left <= '0;
            rsh        <= '0;
            mw_cs      <= 1'b0;
            rd_valid   <= 1'b0;
            rd_data    <= '0;
            done       <= 1'b0;
            timeout    <= 1'b0;
        end else begin
            rd_valid <= 1'b0;
            done     <= 1'b0;
            timeout  <= 1'b0;
            case (state)
                S_IDLE: if (req_valid) begin
                    frame      <= nf.bits;
                    bits_left  <= nf.len;
                    cmd_q      <= cmd_e'(req_cmd);
                    org_q      <= req_org16;
                    words_left <= (req_words == '0) ? WORDS_W'(1) : req_words;
                    mw_cs      <= 1'b1;
                    state      <= S_SEND;
                end
                S_SEND: if (sk_fall) begin
                    frame     <= frame << 1;
                    bits_left <= bits_left - 1'b1;
                    if (bits_left == LEN_W'(1)) begin
                        if (cmd_q == CMD_READ) begin
                            bit_cnt <= dlen;
                            state   <= S_RECV;
                        end else if (is_prog(cmd_q)) begin
                            mw_cs <= 1'b0;
                            state <= S_GAP;
                        end else begin
                            mw_cs <= 1'b0;
                            done  <= 1'b1;
                            state <= S_IDLE;
                        end
                    end
                end
                S_RECV: if (sk_fall) begin
                    rsh     <= {rsh[DW16-2:0], mw_do};
                    bit_cnt <= bit_cnt - 1'b1;
                    if (bit_cnt == BCW'(1)) begin
                        rd_valid   <= 1'b1;
                        rd_data    <= word_in;
                        bit_cnt    <= dlen;
                        words_left <= words_left - 1'b1;
                        if (words_left == WORDS_W'(1)) begin
                            mw_cs <= 1'b0;
                            done  <= 1'b1;
                            state <= S_IDLE;
                        end
                    end
                end
                S_GAP: if (gap_cnt >= gap_lim) begin
                    mw_cs <= 1'b1;
                    state <= S_POLL;
                end
                S_POLL: begin
                    if (poll_cnt != '0 && mw_do) begin
                        mw_cs <= 1'b0;
                        done  <= 1'b1;
                        state <= S_IDLE;
                    end else if (poll_cnt >= tmo_lim) begin
                        mw_cs   <= 1'b0;
                        timeout <= 1'b1;
                        state   <= S_IDLE;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    AST_DI_STABLE: assert property (@(posedge clk) disable iff (rst)
        $rose(mw_sk) |-> $stable(mw_di)) else $error("DI moved at SK rise"); // R4
    AST_SK_NO_CS: assert property (@(posedge clk) disable iff (rst)
        !mw_cs |-> !mw_sk) else $error("SK active without CS"); // R4
    AST_RDV_SRC: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $past(state == S_RECV)) else $error("stray read strobe"); // R5
    AST_GAP_CS_LOW: assert property (@(posedge clk) disable iff (rst)
        (state == S_GAP) |-> !mw_cs) else $error("CS high in gap"); // R7
    AST_TMO_SRC: assert property (@(posedge clk) disable iff (rst)
        timeout |-> $past(state == S_POLL)) else $error("timeout outside poll"); // R8
    AST_END_PULSE: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (done || timeout)) else $error("busy fell silently"); // R9
    AST_END_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(done && timeout)) else $error("done with timeout"); // R9
endmodule

// File: tb/tb_mwh_eeprom_host.sv
module tb_mwh_eeprom_host;
    import mwh_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [2:0]  req_cmd = 3'd0;
    logic        req_org16 = 1'b1;
    logic [8:0]  req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [7:0]  req_words = 8'd1;
    logic [7:0]  cfg_half = 8'd2;
    logic [7:0]  cfg_gap = 8'd5;
    logic [15:0] cfg_tmo = 16'd1000;
    logic        mw_cs, mw_sk, mw_di, mw_do;
    logic        busy, rd_valid, done, timeout;
    logic [15:0] rd_data;

    always #2 clk = ~clk;

    mwh_eeprom_host dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_cmd(req_cmd), .req_org16(req_org16), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_words(req_words), .cfg_half(cfg_half),
        .cfg_gap(cfg_gap), .cfg_tmo(cfg_tmo), .mw_cs(mw_cs), .mw_sk(mw_sk),
        .mw_di(mw_di), .mw_do(mw_do), .busy(busy), .rd_valid(rd_valid),
        .rd_data(rd_data), .done(done), .timeout(timeout)
    );

    int checks = 0;
    int failures = 0;

    // ---------------- behavioural memory model ----------------
    logic [15:0] mmem [0:511];
    logic [15:0] rmem [0:511];
    logic        m_org16 = 1'b1;
    int          busy_len = 20;
    logic        busy_kill = 1'b0;
    longint      cyc = 0;
    longint      busy_until = 0;
    int          m_phase = 0, m_cnt = 0, m_bit = 0, sk_rises = 0;
    logic [1:0]  m_op = '0;
    logic [8:0]  m_addr = '0, m_ptr = '0;
    logic [15:0] m_data = '0;
    logic        m_do = 1'b0, m_status = 1'b0;
    logic [1:0]  rec_op = '0;
    logic [8:0]  rec_addr = '0;
    logic [15:0] rec_data = '0;
    int          rec_rises = 0, cs_rise_total = 0;
    int          hi_run = 0, last_hi = 0, lo_run = 0, last_lo = 0;

    assign mw_do = m_status ? (busy_kill || cyc >= busy_until) : m_do;

    function automatic logic [15:0] init_val(int a);
        return 16'(a * 40503) ^ 16'h5a5a;
    endfunction

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (mw_sk) hi_run = hi_run + 1;
        else begin if (hi_run > 0) last_hi = hi_run; hi_run = 0; end
        if (!mw_cs) lo_run = lo_run + 1;
        else begin if (lo_run > 0) last_lo = lo_run; lo_run = 0; end
    end

    always @(posedge mw_sk or posedge mw_cs or negedge mw_cs) begin
        int alen, dlen;
        logic [1:0] top2;
        alen = m_org16 ? 8 : 9;
        dlen = m_org16 ? 16 : 8;
        if (!mw_cs) begin
            if (sk_rises > 0) begin
                rec_op = m_op; rec_addr = m_addr; rec_data = m_data; rec_rises = sk_rises;
            end
            if (m_status) m_status = 1'b0;
            if (m_phase == 5) begin
                top2 = m_org16 ? m_addr[7:6] : m_addr[8:7];
                if (m_op == 2'b01 || m_op == 2'b11 || (m_op == 2'b00 && top2[1] != top2[0])) begin
                    if (m_op == 2'b01) mmem[m_addr] = m_data;
                    else if (m_op == 2'b11) mmem[m_addr] = 16'hffff;
                    else for (int i = 0; i < 512; i++) mmem[i] = (top2 == 2'b10) ? 16'hffff : m_data;
                    m_status   = 1'b1;
                    busy_until = cyc + busy_len;
                end
            end
            m_phase = 0;
        end else if (!mw_sk) begin
            cs_rise_total = cs_rise_total + 1;
            sk_rises = 0; m_data = '0; m_addr = '0; m_op = '0;
        end else begin
            sk_rises = sk_rises + 1;
            case (m_phase)
                0: if (mw_di) begin m_phase = 1; m_cnt = 0; end
                1: begin
                    m_op = {m_op[0], mw_di}; m_cnt++;
                    if (m_cnt == 2) begin m_phase = 2; m_cnt = 0; end
                end
                2: begin
                    m_addr = {m_addr[7:0], mw_di}; m_cnt++;
                    if (m_cnt == alen) begin
                        top2 = m_org16 ? m_addr[7:6] : m_addr[8:7];
                        m_cnt = 0;
                        if (m_op == 2'b10) begin
                            m_phase = 4; m_do = 1'b0; m_ptr = m_addr; m_bit = dlen;
                        end else if (m_op == 2'b01 || (m_op == 2'b00 && top2 == 2'b01)) m_phase = 3;
                        else m_phase = 5;
                    end
                end
                3: begin
                    m_data = {m_data[14:0], mw_di}; m_cnt++;
                    if (m_cnt == dlen) m_phase = 5;
                end
                4: begin
                    if (m_bit == 0) begin
                        m_ptr = m_org16 ? {1'b0, 8'(m_ptr + 1)} : 9'(m_ptr + 1);
                        m_bit = dlen;
                    end
                    m_do = mmem[m_ptr][m_bit-1]; m_bit--;
                end
                default: ;
            endcase
        end
    end

    // ---------------- bench helpers ----------------
    logic [15:0] got [0:15];
    int          got_n;
    logic        saw_done, saw_tmo;

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [1:0] exp_op(int c);
        case (c) 0: return 2'b10; 1: return 2'b01; 2: return 2'b11; default: return 2'b00; endcase
    endfunction

    function automatic logic [8:0] exp_addr(int c, logic org, logic [8:0] a);
        int alen = org ? 8 : 9;
        logic [1:0] sub;
        case (c) 3: sub = 2'b11; 5: sub = 2'b10; 6: sub = 2'b01; default: sub = 2'b00; endcase
        if (c <= 2) return org ? {1'b0, a[7:0]} : a;
        return 9'(sub) << (alen - 2);
    endfunction

    task automatic run_cmd(input int c, input logic org, input logic [8:0] a,
                           input logic [15:0] wd, input int n);
        int guard = 0;
        @(negedge clk);
        m_org16 = org; req_cmd = 3'(c); req_org16 = org; req_addr = a;
        req_wdata = wd; req_words = 8'(n); req_valid = 1'b1;
        got_n = 0; saw_done = 0; saw_tmo = 0;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R9 busy/ready during sequence", {busy, req_ready}, 2'b10);
        while (!saw_done && !saw_tmo && guard < 40000) begin
            if (rd_valid && got_n < 16) begin got[got_n] = rd_data; got_n++; end
            if (done) saw_done = 1;
            if (timeout) saw_tmo = 1;
            if (!saw_done && !saw_tmo) @(negedge clk);
            guard++;
        end
        chk("R9 single end pulse", {saw_done, saw_tmo} == 2'b00 ? 0 : ((saw_done ^ saw_tmo) ? 1 : 2), 1);
        @(negedge clk);
        chk("R9 idle after end", {busy, req_ready, done, timeout}, 4'b0100);
    endtask

    task automatic do_op(input int c, input logic org, input logic [8:0] a,
                         input logic [15:0] wd, input int n);
        int alen = org ? 8 : 9;
        int dlen = org ? 16 : 8;
        int nw = (n == 0) ? 1 : n;
        int rises;
        int cr0 = cs_rise_total;
        logic prog = (c == 1 || c == 2 || c == 5 || c == 6);
        logic [15:0] dmask = org ? 16'hffff : 16'h00ff;
        run_cmd(c, org, a, wd, n);
        chk("R1 opcode", rec_op, exp_op(c));
        if (c >= 3) chk("R3 address field", rec_addr, exp_addr(c, org, a));
        else chk("R2 address field", rec_addr, exp_addr(c, org, a));
        if (c == 1 || c == 6) chk("R2 data field", rec_data, wd & dmask);
        rises = 3 + alen + ((c == 1 || c == 6) ? dlen : 0) + ((c == 0) ? nw * dlen : 0);
        chk(c == 0 ? "R6 SK rise count" : "R2 SK rise count", rec_rises, rises);
        chk("R9 done seen", saw_done, 1);
        if (prog) begin
            chk("R7 CS rises", cs_rise_total - cr0, 2);
            chk("R7 gap width", last_lo, (cfg_gap == 0) ? 1 : cfg_gap);
        end else begin
            chk("R11 single CS rise", cs_rise_total - cr0, 1);
        end
        if (c == 0) begin
            chk("R6 word count", got_n, nw);
            for (int i = 0; i < nw && i < got_n; i++) begin
                int ad = org ? ((a + i) & 255) : ((a + i) & 511);
                chk("R5 read word", got[i], rmem[ad] & dmask);
            end
        end
        if (c == 1) rmem[org ? {1'b0, a[7:0]} : a] = wd & dmask;
        if (c == 2) rmem[org ? {1'b0, a[7:0]} : a] = 16'hffff;
        if (c == 5) for (int i = 0; i < 512; i++) rmem[i] = 16'hffff;
        if (c == 6) for (int i = 0; i < 512; i++) rmem[i] = wd & dmask;
    endtask

    initial begin
        for (int i = 0; i < 512; i++) begin mmem[i] = init_val(i); rmem[i] = init_val(i); end
        void'($urandom(32'h5eed_0057));
        fork
            begin
                repeat (4) @(posedge clk);
                @(negedge clk) rst = 1'b0;
                @(negedge clk);
                chk("R10 reset outputs", {mw_cs, mw_sk, busy, rd_valid, done, timeout, req_ready}, 7'b0000001);

                // directed x16 write, read-back burst
                cfg_half = 2; cfg_gap = 5; busy_len = 30;
                do_op(1, 1'b1, 9'h012, 16'hBEEF, 1);
                chk("R4 SK high width", last_hi, 2);
                do_op(0, 1'b1, 9'h011, 16'h0, 3);
                // x8 write and read with a 9-bit address
                do_op(1, 1'b0, 9'h1A5, 16'h12C3, 1);
                do_op(0, 1'b0, 9'h1A4, 16'h0, 3);
                // burst wrap and zero-length burst
                do_op(0, 1'b1, 9'h0FE, 16'h0, 4);
                do_op(0, 1'b0, 9'h1FF, 16'h0, 2);
                do_op(0, 1'b1, 9'h033, 16'h0, 0);
                // enable/disable and single erase
                do_op(3, 1'b1, 9'h155, 16'h0, 1);
                do_op(4, 1'b0, 9'h0AA, 16'h0, 1);
                do_op(2, 1'b0, 9'h1A5, 16'h0, 1);
                do_op(0, 1'b0, 9'h1A5, 16'h0, 1);
                // half period zero behaves as one, gap zero as one
                cfg_half = 0; cfg_gap = 0;
                do_op(1, 1'b1, 9'h040, 16'h1357, 1);
                chk("R4 SK high width min", last_hi, 1);
                cfg_half = 1; cfg_gap = 3;
                // random mix
                for (int it = 0; it < 24; it++) begin
                    logic org = 1'($urandom);
                    logic [8:0] a = 9'($urandom);
                    logic [15:0] wd = 16'($urandom);
                    cfg_half = 8'(1 + $urandom % 3);
                    cfg_gap  = 8'(1 + $urandom % 6);
                    busy_len = 5 + $urandom % 40;
                    do_op(1, org, a, wd, 1);
                    do_op(0, org, 9'(a - ($urandom % 2)), 16'h0, 1 + $urandom % 4);
                end
                // whole-array commands
                do_op(6, 1'b1, 9'h0, 16'hA5C3, 1);
                do_op(0, 1'b1, 9'h07F, 16'h0, 2);
                do_op(5, 1'b0, 9'h0, 16'h0, 1);
                do_op(0, 1'b0, 9'h100, 16'h0, 2);
                // poll timeout
                cfg_tmo = 40; busy_len = 100000;
                run_cmd(1, 1'b1, 9'h020, 16'h4444, 1);
                chk("R8 timeout pulse", saw_tmo, 1);
                chk("R8 no done", saw_done, 0);
                chk("R8 CS low after", mw_cs, 0);
                busy_kill = 1'b1;
                rmem[9'h020] = 16'h4444;
                cfg_tmo = 1000; busy_len = 10;
                repeat (2) @(negedge clk);
                busy_kill = 1'b0;
                do_op(0, 1'b1, 9'h020, 16'h0, 1);
            end
            begin
                repeat (190000) @(posedge clk);
                checks++; failures++;
                $display("FAIL watchdog expired act=hung exp=finished");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule